// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs a single bus master's transfer cycles on a bus where the low address bits and the data share one set of lines. Each transfer is a read or a write to memory or I/O space. It steps through the T-states T1, T2, T3, any number of wait states TW, and T4. At each step it drives the address strobe, the read and write strobes, the space select, the upper-byte enable, the transceiver direction and enable, and the output enable of the shared lines.

The block runs on a fast clock that is twice the bus state rate. Each T-state lasts two fast clocks: a first half (phase 0) and a second half (phase 1). This lets strobes change in the middle of a T-state. A free-running phase bit tracks the halves. A request side accepts one cycle at a time. A hold handshake gives the bus to another master, but only between cycles. While the bus is granted away, the bus and control drivers are released.

Top module: `bus_cycle_seq`

## Requirements
- R1: In both halves of T1, `ale` is 1 and `ad_oe` is 1. In T1, `ad_out` carries `req_addr[DW-1:0]` and `a_hi` carries `req_addr[AW-1:DW]`. Outside T1, `ale` is 0 and `a_hi` is 0.
- R2: For a read, `rd_n` is 0 from the second half of T2 through T3 and every wait state. It is 1 in the first half of T2, in T1 and in T4.
- R3: For a write, `wr_n` is 0 from the first half of T2 through T3 and every wait state. `ad_out` carries the write data with `ad_oe` at 1 from T2 through the first half of T4. For a read, `ad_oe` is 0 after T1.
- R4: `den` is 1 from the second half of T2 up to and including the first half of T4, and 0 elsewhere. From T1 to T4, `dt_tx` is 1 for a write and 0 for a read.
- R5: `mio` is 1 for memory and 0 for I/O (`req_io` = 0 means memory). It takes its value at the clock edge that accepts a request. It stays unchanged until the next request is accepted.
- R6: `ready` is sampled at the end of the second half of T3 and of every wait state. If it is 0 there, one more wait state of two halves follows. If it is 1, T4 follows.
- R7: In T1, `bhe_n` is 0 exactly when `req_hi` was 1 for the request. Outside T1, `bhe_n` is 1.
- R8: `hold_req` is checked only at the end of T4 and at the end of the second half of an idle state. When it is seen there, `hlda` rises at that edge. While `hlda` is 1, `ad_oe`, `ctl_oe` and `ale` are 0. A `hold_req` raised during a cycle does not change that cycle's strobes.
- R9: While granted, at the end of a second half with `hold_req` at 0, `hlda` falls and `ctl_oe` returns to 1.
- R10: `req_ready` is 1 only in the second half of an idle state with `hold_req` at 0. A request is accepted at an edge where `req_valid` and `req_ready` are both 1. T1 begins at that edge. With `hold_req` at 1, no cycle starts.
- R11: For a read, the value on `ad_in` at the edge that ends the last wait state or T3 appears on `rd_data`. During the first half of T4, `rd_valid` is 1. At all other times `rd_valid` is 0.
- R12: After reset the block is idle in phase 0 with `ale`=0, `rd_n`=1, `wr_n`=1, `den`=0, `ad_oe`=0, `dt_tx`=0, `bhe_n`=1, `mio`=1, `ctl_oe`=1, `hlda`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two per T-state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request present |
| req_ready | output | 1 | Request can be taken at this edge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_hi | input | 1 | Upper data byte takes part |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| rd_data | output | DW | Captured read data |
| rd_valid | output | 1 | Read data valid, first half of T4 |
| ad_out | output | DW | Shared address/data lines, out |
| ad_in | input | DW | Shared address/data lines, in |
| ad_oe | output | 1 | Drive enable for the shared lines |
| a_hi | output | AW-DW | Upper address bits, T1 only |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den | output | 1 | Transceiver enable |
| dt_tx | output | 1 | Transceiver direction, 1 = master sends |
| mio | output | 1 | 1 = memory, 0 = I/O |
| bhe_n | output | 1 | Upper-byte enable, active low |
| ctl_oe | output | 1 | Control strobe drive enable |
| ready | input | 1 | Slave ready, active high |
| hold_req | input | 1 | Other master wants the bus |
| hlda | output | 1 | Bus granted away |

## Verification
On every cycle, the assertions check these invariants: the read and write strobes are never both active; the address strobe always comes with the bus driven and never with the transceiver enabled; a write strobe always has data driven; the space select holds while a strobe is active; a grant releases every driver and only follows a request to hold; and no request is offered while granted. Some behaviour can only be shown by the bench's scenarios. These are the exact half-cycle edges of each strobe, the number of wait states that follow a given `ready` pattern, the captured read value, and the point where a hold raised mid-cycle takes effect. The bench checks these against a timeline it builds for each request.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } tstate_e;

    typedef struct packed {
        logic wr;
        logic io;
        logic hi;
    } cyc_attr_t;

    // strobe window shared by T3 and wait states
    function automatic logic mid_cycle(tstate_e s);
        return (s == ST_T3) || (s == ST_TW);
    endfunction

    // transceiver enable window: second half of T2 to first half of T4
    function automatic logic den_window(tstate_e s, logic ph);
        return (s == ST_T2 && ph) || mid_cycle(s) || (s == ST_T4 && !ph);
    endfunction

    // interval in which a write keeps data on the shared lines
    function automatic logic wdata_window(tstate_e s, logic ph);
        return (s == ST_T2) || mid_cycle(s) || (s == ST_T4 && !ph);
    endfunction

    function automatic logic in_cycle(tstate_e s);
        return (s == ST_T1) || (s == ST_T2) || mid_cycle(s) || (s == ST_T4);
    endfunction

endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    ready,
    input  logic    hold_req,
    output tstate_e st,
    output logic    ph,
    output logic    req_ready,
    output logic    accept,
    output logic    sample_end
);

    tstate_e st_q, st_d;
    logic    ph_q;

    assign st         = st_q;
    assign ph         = ph_q;
    assign req_ready  = (st_q == ST_IDLE) && ph_q && !hold_req;
    assign accept     = req_ready && req_valid;
    assign sample_end = ph_q && mid_cycle(st_q) && ready;

    always_comb begin
        st_d = st_q;
        if (ph_q) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (hold_req)       st_d = ST_HOLD;
                    else if (req_valid) st_d = ST_T1;
                end
                ST_T1:   st_d = ST_T2;
                ST_T2:   st_d = ST_T3;
                ST_T3,
                ST_TW:   st_d = ready ? ST_T4 : ST_TW;
                ST_T4:   st_d = hold_req ? ST_HOLD : ST_IDLE;
                ST_HOLD: if (!hold_req) st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            ph_q <= 1'b0;
        end else begin
            st_q <= st_d;
            ph_q <= ~ph_q;
        end
    end

endmodule

// File: rtl/bseq_lat.sv
module bseq_lat
    import bseq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            req_wr,
    input  logic            req_io,
    input  logic            req_hi,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            sample_end,
    input  logic [DW-1:0]   ad_in,
    output cyc_attr_t       attr,
    output logic [AW-1:0]   addr_q,
    output logic [DW-1:0]   wdata_q,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            attr    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            attr    <= '{wr: req_wr, io: req_io, hi: req_hi};
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= sample_end && !attr.wr;
            if (sample_end && !attr.wr) rd_data <= ad_in;
        end
    end

endmodule

// File: rtl/bseq_drv.sv
module bseq_drv
    import bseq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  tstate_e          st,
    input  logic             ph,
    input  cyc_attr_t        attr,
    input  logic [AW-1:0]    addr_q,
    input  logic [DW-1:0]    wdata_q,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             den,
    output logic             dt_tx,
    output logic             mio,
    output logic             bhe_n,
    output logic             ctl_oe,
    output logic             hlda
);

    logic addr_ph;

    assign addr_ph = (st == ST_T1);
    assign ale     = addr_ph;
    assign a_hi    = addr_ph ? addr_q[AW-1:DW] : '0;
    assign ad_out  = addr_ph ? addr_q[DW-1:0] : wdata_q;
    assign ad_oe   = addr_ph || (attr.wr && wdata_window(st, ph));
    assign bhe_n   = !(addr_ph && attr.hi);

    // read strobe held off for the first half of T2 to let the bus float
    assign rd_n    = !(!attr.wr && ((st == ST_T2 && ph) || mid_cycle(st)));
    assign wr_n    = !(attr.wr && ((st == ST_T2) || mid_cycle(st)));
    assign den     = den_window(st, ph);
    assign dt_tx   = attr.wr && in_cycle(st);
    assign mio     = !attr.io;
    assign hlda    = (st == ST_HOLD);
    assign ctl_oe  = !hlda;

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bseq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_wr,
    input  logic             req_io,
    input  logic             req_hi,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic [DW-1:0]    ad_out,
    input  logic [DW-1:0]    ad_in,
    output logic             ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             den,
    output logic             dt_tx,
    output logic             mio,
    output logic             bhe_n,
    output logic             ctl_oe,
    input  logic             ready,
    input  logic             hold_req,
    output logic             hlda
);

    tstate_e         st;
    logic            ph;
    logic            accept;
    logic            sample_end;
    cyc_attr_t       attr;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;

    bseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .ready      (ready),
        .hold_req   (hold_req),
        .st         (st),
        .ph         (ph),
        .req_ready  (req_ready),
        .accept     (accept),
        .sample_end (sample_end)
    );

    bseq_lat #(.AW(AW), .DW(DW)) u_lat (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_wr     (req_wr),
        .req_io     (req_io),
        .req_hi     (req_hi),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .sample_end (sample_end),
        .ad_in      (ad_in),
        .attr       (attr),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    bseq_drv #(.AW(AW), .DW(DW)) u_drv (
        .st      (st),
        .ph      (ph),
        .attr    (attr),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .a_hi    (a_hi),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .den     (den),
        .dt_tx   (dt_tx),
        .mio     (mio),
        .bhe_n   (bhe_n),
        .ctl_oe  (ctl_oe),
        .hlda    (hlda)
    );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den,
    input logic ad_oe,
    input logic ctl_oe,
    input logic hlda,
    input logic hold_req,
    input logic mio,
    input logic req_ready
);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R2

    AST_ALE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
        ale |-> ad_oe); // R1

    AST_ALE_NOT_WITH_DEN: assert property (@(posedge clk) disable iff (rst)
        ale |-> !den); // R4

    AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe); // R3

    AST_MIO_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |=> $stable(mio)); // R5

    AST_GRANT_RELEASES: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ad_oe && !ctl_oe && !ale && !den)); // R8

    AST_GRANT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> $past(hold_req)); // R8

    AST_NO_OFFER_GRANTED: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!hlda && !hold_req)); // R10

endmodule

bind bus_cycle_seq bseq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den       (den),
    .ad_oe     (ad_oe),
    .ctl_oe    (ctl_oe),
    .hlda      (hlda),
    .hold_req  (hold_req),
    .mio       (mio),
    .req_ready (req_ready)
);

// File: tb/bus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb_top;

    localparam int AW = 20;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic             req_valid = 1'b0, req_wr = 1'b0, req_io = 1'b0, req_hi = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_wdata = '0, ad_in = '0;
    logic             ready = 1'b1, hold_req = 1'b0;
    logic             req_ready, rd_valid, ad_oe, ale, rd_n, wr_n, den, dt_tx, mio, bhe_n, ctl_oe, hlda;
    logic [DW-1:0]    rd_data, ad_out;
    logic [AW-DW-1:0] a_hi;

    bus_cycle_seq #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_io(req_io), .req_hi(req_hi), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .den(den), .dt_tx(dt_tx), .mio(mio),
        .bhe_n(bhe_n), .ctl_oe(ctl_oe), .ready(ready), .hold_req(hold_req),
        .hlda(hlda)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    typedef struct {
        logic ale, oe, rdn, wrn, den, dt, mio, bhen, ctl, hlda, rdv;
        logic check_bus, check_mio;
        logic [DW-1:0]    bus;
        logic [AW-DW-1:0] ahi;
        logic [DW-1:0]    rdat;
        logic drv_ready, drv_hold;
        string where;
    } item_t;

    item_t sb_q[$];

    // monitor: one expected item per fast clock, compared at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                chk(ale == it.ale,     {"R1 ale ", it.where}, ale, it.ale);
                chk(a_hi == it.ahi,    {"R1 a_hi ", it.where}, a_hi, it.ahi);
                chk(ad_oe == it.oe,    {"R3 ad_oe ", it.where}, ad_oe, it.oe);
                if (it.check_bus)
                    chk(ad_out == it.bus, {"R3 ad_out ", it.where}, ad_out, it.bus);
                chk(rd_n == it.rdn,    {"R2 rd_n ", it.where}, rd_n, it.rdn);
                chk(wr_n == it.wrn,    {"R3 wr_n ", it.where}, wr_n, it.wrn);
                chk(den == it.den,     {"R4 den ", it.where}, den, it.den);
                chk(dt_tx == it.dt,    {"R4 dt_tx ", it.where}, dt_tx, it.dt);
                if (it.check_mio)
                    chk(mio == it.mio, {"R5 mio ", it.where}, mio, it.mio);
                chk(bhe_n == it.bhen,  {"R7 bhe_n ", it.where}, bhe_n, it.bhen);
                chk(hlda == it.hlda,   {"R8 hlda ", it.where}, hlda, it.hlda);
                chk(ctl_oe == it.ctl,  {"R8 ctl_oe ", it.where}, ctl_oe, it.ctl);
                chk(rd_valid == it.rdv, {"R11 rd_valid ", it.where}, rd_valid, it.rdv);
                if (it.rdv)
                    chk(rd_data == it.rdat, {"R11 rd_data ", it.where}, rd_data, it.rdat);
                ready    = it.drv_ready;
                hold_req = it.drv_hold;
            end
        end
    end

    // kind: 1=T1 2=T2 3=T3 4=TW 5=T4 6=granted
    function automatic item_t mk(input int kind, input logic h, input logic wr, input logic io,
                                 input logic hi, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                                 input logic [DW-1:0] rin, input logic drdy, input logic dhold);
        item_t it;
        logic t1, t2, mid, t4, g;
        t1 = (kind == 1); t2 = (kind == 2); mid = (kind == 3 || kind == 4);
        t4 = (kind == 5); g = (kind == 6);
        it.ale  = t1;
        it.ahi  = t1 ? a[AW-1:DW] : '0;
        it.oe   = t1 || (wr && (t2 || mid || (t4 && !h)));
        it.check_bus = it.oe;
        it.bus  = t1 ? a[DW-1:0] : wd;
        it.rdn  = !(!wr && ((t2 && h) || mid));
        it.wrn  = !(wr && (t2 || mid));
        it.den  = (t2 && h) || mid || (t4 && !h);
        it.dt   = wr && !g;
        it.mio  = !io;
        it.check_mio = !g;
        it.bhen = !(t1 && hi);
        it.hlda = g;
        it.ctl  = !g;
        it.rdv  = t4 && !h && !wr;
        it.rdat = rin;
        it.drv_ready = drdy;
        it.drv_hold  = dhold;
        it.where = $sformatf("kind%0d/h%0d", kind, h);
        return it;
    endfunction

    task automatic run_cycle(input logic wr, input logic io, input logic hi,
                             input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input logic [DW-1:0] rin, input int nw, input logic hold_mid);
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        req_valid = 1'b1; req_wr = wr; req_io = io; req_hi = hi;
        req_addr = a; req_wdata = wd; ad_in = rin; ready = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_wdata = ~wd; req_addr = ~a;   // request inputs must no longer matter (R10)
        sb_q.push_back(mk(1, 0, wr, io, hi, a, wd, rin, 0, 0));
        sb_q.push_back(mk(1, 1, wr, io, hi, a, wd, rin, 0, 0));
        sb_q.push_back(mk(2, 0, wr, io, hi, a, wd, rin, 0, hold_mid));
        sb_q.push_back(mk(2, 1, wr, io, hi, a, wd, rin, 0, hold_mid));
        sb_q.push_back(mk(3, 0, wr, io, hi, a, wd, rin, 0, hold_mid));
        sb_q.push_back(mk(3, 1, wr, io, hi, a, wd, rin, nw == 0, hold_mid)); // R6
        for (int k = 0; k < nw; k++) begin
            sb_q.push_back(mk(4, 0, wr, io, hi, a, wd, rin, 0, hold_mid));
            sb_q.push_back(mk(4, 1, wr, io, hi, a, wd, rin, k == nw - 1, hold_mid)); // R6
        end
        sb_q.push_back(mk(5, 0, wr, io, hi, a, wd, rin, 1, hold_mid));
        sb_q.push_back(mk(5, 1, wr, io, hi, a, wd, rin, 1, hold_mid));
        if (hold_mid) begin
            sb_q.push_back(mk(6, 0, wr, io, hi, a, wd, rin, 1, 1)); // R8
            sb_q.push_back(mk(6, 1, wr, io, hi, a, wd, rin, 1, 1));
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    task automatic hold_release();
        int n = 0;
        hold_req = 1'b0;
        while (hlda && n < 6) begin @(negedge clk); n++; end
        chk(!hlda && n <= 3, "R9 hlda falls", n, 3);
        chk(ctl_oe == 1'b1, "R9 ctl_oe back", ctl_oe, 1);
    endtask

    task automatic hold_idle_test();
        int n = 0;
        @(posedge clk); #1;
        hold_req = 1'b1;
        while (!hlda && n < 6) begin @(negedge clk); n++; end
        chk(hlda && n <= 3, "R8 hlda from idle", n, 3);
        chk(!ad_oe && !ctl_oe && !ale, "R8 released", {ad_oe, ctl_oe, ale}, 0);
        req_valid = 1'b1; req_wr = 1'b0; req_addr = 20'h12345;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!req_ready && !ale, "R10 no start while held", {req_ready, ale}, 0);
        end
        req_valid = 1'b0;
        hold_release();
    endtask

    initial begin
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!ale && rd_n && wr_n && !den && !ad_oe && !dt_tx, "R12 reset strobes",
            {ale, rd_n, wr_n, den, ad_oe, dt_tx}, 6'b011000);
        chk(bhe_n && mio && ctl_oe && !hlda && !rd_valid, "R12 reset misc",
            {bhe_n, mio, ctl_oe, hlda, rd_valid}, 5'b11100);
        chk(!req_ready, "R12 phase 0 after reset", req_ready, 0);

        run_cycle(0, 0, 1, 20'hA5C3E, 16'h0000, 16'hBEEF, 0, 0); // mem read, both bytes
        run_cycle(1, 1, 1, 20'h00371, 16'h5A69, 16'h0000, 1, 0); // io write, 1 wait
        run_cycle(0, 1, 0, 20'h00042, 16'h0000, 16'h1234, 3, 0); // io read, 3 waits
        run_cycle(1, 0, 0, 20'hF0F0F, 16'hC0DE, 16'h0000, 0, 1); // mem write, hold mid-cycle
        req_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!req_ready && !ale, "R10 held after cycle", {req_ready, ale}, 0);
        end
        req_valid = 1'b0;
        hold_release();
        hold_idle_test();
        run_cycle(0, 0, 0, 20'h7FFFE, 16'h0000, 16'h8001, 2, 0); // mem read after release
        run_cycle(1, 0, 1, 20'h12340, 16'hFFFF, 16'h0000, 0, 0); // write back-to-back

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule